// File: doc/BRIEF.md
# Programmable Pulse-Pattern Bit Encoder

This block is a serial transmitter for infrared and RF remote-control links. It takes one data word at a time and sends its bits one after another, least significant bit first. Each bit does not go out as a plain level. It is replaced by a short pattern of pattern bits that software chooses, with one pattern for a logical 0 and another for a logical 1. By choosing these patterns, one block can produce pulse-distance, Manchester-like or other encodings. Each pattern bit is held on the output for a number of clock cycles set by a prescale value, which fixes the symbol rate.

Words arrive on a valid/ready stream. A word is taken only when the level input `start` is high, and the block is either idle or in the last cycle of the current message. The upstream side may hold `data_valid` high for as long as it likes, because back-pressure through `data_ready` stalls it without losing the word. The pattern, the prescale value and the pin select are sampled when a word is accepted. The encoded stream leaves on one of two output pins, and the pin that is not selected stays low.

`done` pulses for one cycle when a message finishes. If another word is presented in that same cycle while `start` is still high, that word begins on the next cycle with no gap. If `start` is pulled low during a message, the message is abandoned at the end of the pattern bit that is on the wire, and no `done` pulse follows.

Top module: `ir_bit_encoder`

## Requirements
- R1: After reset, and whenever no message is in progress, both `tx` pins are 0 and `done` is 0.
- R2: `data_ready` is 1 only when `start` is 1 and the block is either idle or in the final cycle of a message. A word is taken on a clock edge where both `data_valid` and `data_ready` are 1. While `data_ready` is 0, a held word is neither consumed nor lost.
- R3: The 8 data bits are sent bit 0 first. Each bit is sent as 4 pattern bits, most significant first. Bits [3:0] of `bit_pattern` encode a 0 and bits [7:4] encode a 1.
- R4: Every pattern bit stays on the output for exactly `prescale`+1 clock cycles. The first pattern bit appears in the cycle after the word is accepted.
- R5: When `out_sel` is 0 the stream drives `tx[0]`; when it is 1 the stream drives `tx[1]`. The other pin stays 0.
- R6: `done` is 1 for exactly one cycle per completed message: the last cycle of the last pattern bit.
- R7: A word accepted in the `done` cycle starts its first pattern bit in the very next cycle, so no idle cycle falls between the two messages.
- R8: If `start` is 0 at the end of a pattern bit, the message stops. `tx` is 0 from the next cycle on and `done` does not pulse.
- R9: `bit_pattern`, `prescale` and `out_sel` are sampled when a word is accepted. Changing them during a message has no effect on that message.
- R10: While idle with `start` at 0, `data_valid` is ignored: `data_ready` stays 0 and `tx` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Level enable; low aborts at the next pattern-bit boundary |
| out_sel | input | 1 | Selects which `tx` pin carries the stream |
| prescale | input | 8 | Cycles per pattern bit, minus one |
| bit_pattern | input | 8 | [7:4] pattern for a 1, [3:0] pattern for a 0 |
| data_valid | input | 1 | Stream word valid |
| data_ready | output | 1 | Stream word accepted when high with valid |
| data_word | input | 8 | Word to transmit |
| tx | output | 2 | Encoded output pins |
| done | output | 1 | One-cycle message-complete pulse |

## Verification
Once a word is accepted, cycle n of the message (counting from 0 in the cycle after the accept edge) carries pattern bit n/(prescale+1). The bench therefore computes the expected level of every cycle from the word, the pattern and the prescale value. The outputs `tx`, `done` and `data_ready` come combinationally from registered state, so the bench drives inputs and samples outputs on the falling edge. Each cycle it compares the outputs with that cycle's expected values, and it expects `done` and `data_ready` only at cycle 32·(prescale+1)−1. For an abort, the output must still follow the pattern up to the end of the current pattern bit and must be 0 from the next cycle on. Mid-message changes to the configuration are applied after the accept edge, and the bench still expects the values sampled at the accept.

// File: rtl/ir_enc_pkg.sv
package ir_enc_pkg;
  typedef enum logic {
    ENC_IDLE = 1'b0,
    ENC_SEND = 1'b1
  } enc_state_t;
endpackage

// File: rtl/enc_tick_gen.sv
module enc_tick_gen #(
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] limit,
  output logic            tick
);
  logic [PS_W-1:0] cnt_q;

  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  // R4: between ticks the divider advances by one each cycle
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (cnt_q == PS_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/enc_bit_seq.sv
module enc_bit_seq #(
  parameter int DATA_W = 8,
  parameter int PAT_W  = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  load,
  input  logic [DATA_W-1:0]                     word_in,
  input  logic                                  adv,
  output logic                                  cur_bit,
  output logic [((PAT_W > 1) ? $clog2(PAT_W) : 1)-1:0] slot,
  output logic                                  last_slot
);
  localparam int SLOT_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;
  localparam int BIT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(PAT_W - 1);
  localparam logic [BIT_W-1:0]  BIT_MAX  = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] word_q;
  logic [SLOT_W-1:0] slot_q;
  logic [BIT_W-1:0]  bit_q;
  logic              slot_end;

  assign slot_end  = (slot_q == SLOT_MAX);
  assign cur_bit   = word_q[0];
  assign slot      = slot_q;
  assign last_slot = slot_end && (bit_q == BIT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      slot_q <= '0;
      bit_q  <= '0;
    end else if (load) begin
      word_q <= word_in;
      slot_q <= '0;
      bit_q  <= '0;
    end else if (adv) begin
      if (slot_end) begin
        slot_q <= '0;
        bit_q  <= bit_q + 1'b1;
        word_q <= word_q >> 1;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  // R3: the next data bit is presented only after the last pattern bit of the current one
  a_r3_lsb_order: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && slot_end) |=> (word_q == ($past(word_q) >> 1)));
endmodule

// File: rtl/enc_out_route.sv
module enc_out_route #(
  parameter int N_OUT = 2,
  parameter int SEL_W = 1
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic             level,
  output logic [N_OUT-1:0] tx
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_pin
    assign tx[g] = en && level && (sel == SEL_W'(g));
  end
endmodule

// File: rtl/ir_bit_encoder.sv
module ir_bit_encoder #(
  parameter int DATA_W = 8,
  parameter int PAT_W  = 4,
  parameter int PS_W   = 8,
  parameter int N_OUT  = 2,
  parameter int SEL_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SEL_W-1:0]   out_sel,
  input  logic [PS_W-1:0]    prescale,
  input  logic [2*PAT_W-1:0] bit_pattern,
  input  logic               data_valid,
  output logic               data_ready,
  input  logic [DATA_W-1:0]  data_word,
  output logic [N_OUT-1:0]   tx,
  output logic               done
);
  import ir_enc_pkg::*;

  localparam int SLOT_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;

  enc_state_t         state_q;
  logic [2*PAT_W-1:0] pat_q;
  logic [PS_W-1:0]    ps_q;
  logic [SEL_W-1:0]   sel_q;

  logic              busy;
  logic              tick;
  logic              cur_bit;
  logic [SLOT_W-1:0] slot;
  logic              last_slot;
  logic              last_tick;
  logic              accept;
  logic [PAT_W-1:0]  pat_sel;
  logic [PAT_W-1:0]  pat_shift;
  logic              level;

  assign busy       = (state_q == ENC_SEND);
  assign last_tick  = busy && tick && last_slot;
  assign done       = last_tick;
  assign data_ready = start && (!busy || last_tick);
  assign accept     = data_valid && data_ready;

  enc_tick_gen #(.PS_W(PS_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .limit (ps_q),
    .tick  (tick)
  );

  enc_bit_seq #(.DATA_W(DATA_W), .PAT_W(PAT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .word_in   (data_word),
    .adv       (busy && tick),
    .cur_bit   (cur_bit),
    .slot      (slot),
    .last_slot (last_slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ENC_IDLE;
      pat_q   <= '0;
      ps_q    <= '0;
      sel_q   <= '0;
    end else if (accept) begin
      state_q <= ENC_SEND;
      pat_q   <= bit_pattern;
      ps_q    <= prescale;
      sel_q   <= out_sel;
    end else if (busy && tick && (!start || last_slot)) begin
      state_q <= ENC_IDLE;
    end
  end

  assign pat_sel   = cur_bit ? pat_q[2*PAT_W-1:PAT_W] : pat_q[PAT_W-1:0];
  assign pat_shift = pat_sel << slot;
  assign level     = pat_shift[PAT_W-1];

  enc_out_route #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_route (
    .en    (busy),
    .sel   (sel_q),
    .level (level),
    .tx    (tx)
  );

  // R1: nothing on the pins outside a message
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tx == '0 && !done));
  // R2: no acceptance without start
  a_r2_ready_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> start);
  // R5: at most one pin is driven
  a_r5_single_pin: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx));
  // R6: completion is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: a word taken at completion keeps the block busy
  a_r7_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (done && data_valid && start) |=> busy);
  // R8: start low at a pattern-bit boundary ends the message
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick && !start) |=> !busy);
  // R9: configuration holds for the whole message
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(accept)) |-> $stable(pat_q) && $stable(ps_q) && $stable(sel_q));
endmodule

// File: tb/ir_bit_encoder_bench.sv
`timescale 1ns/1ps
module ir_bit_encoder_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [0:0] out_sel;
  logic [7:0] prescale;
  logic [7:0] bit_pattern;
  logic       data_valid;
  logic       data_ready;
  logic [7:0] data_word;
  logic [1:0] tx;
  logic       done;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  ir_bit_encoder u_ir_bit_encoder (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .out_sel     (out_sel),
    .prescale    (prescale),
    .bit_pattern (bit_pattern),
    .data_valid  (data_valid),
    .data_ready  (data_ready),
    .data_word   (data_word),
    .tx          (tx),
    .done        (done)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_level(input logic [7:0] w, input logic [7:0] pat,
                                     input int ps, input int n);
    int s;
    int b;
    int sl;
    logic [3:0] p;
    s  = n / (ps + 1);
    b  = s / 4;
    sl = s % 4;
    p  = w[b] ? pat[7:4] : pat[3:0];
    return p[3 - sl];
  endfunction

  function automatic int exp_tx(input logic lvl, input int sel);
    return lvl ? (1 << sel) : 0;
  endfunction

  task automatic launch(input logic [7:0] w, input logic [7:0] pat, input int ps, input int sel);
    @(negedge clk);
    bit_pattern = pat;
    prescale    = 8'(ps);
    out_sel     = 1'(sel);
    start       = 1'b1;
    data_word   = w;
    data_valid  = 1'b1;
    #1;
    chk("R2 ready when idle and started", int'(data_ready), 1);
  endtask

  task automatic stream(input logic [7:0] w, input logic [7:0] pat, input int ps, input int sel,
                        input bit hold, input logic [7:0] nxt, input bit scramble, input string tag);
    int tot;
    tot = 32 * (ps + 1);
    for (int n = 0; n < tot; n++) begin
      @(negedge clk);
      if (n == 0) begin
        data_valid = hold;
        if (hold) data_word = nxt;
      end
      if (scramble && n == 3) begin
        bit_pattern = ~pat;
        prescale    = 8'(ps + 3);
        out_sel     = 1'(~sel);
      end
      #1;
      chk({tag, " tx"}, int'(tx), exp_tx(exp_level(w, pat, ps, n), sel));
      chk({tag, " R6 done"}, int'(done), (n == tot - 1) ? 1 : 0);
      chk({tag, " R2 ready"}, int'(data_ready), (n == tot - 1) ? 1 : 0);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 1'b0; out_sel = '0; prescale = '0;
    bit_pattern = '0; data_valid = 1'b0; data_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset tx", int'(tx), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset ready", int'(data_ready), 0);
  endtask

  task automatic t_idle_ignore;
    @(negedge clk);
    start = 1'b0; data_valid = 1'b1; data_word = 8'hFF; bit_pattern = 8'hFF;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      #1;
      chk("R10 ready stays low", int'(data_ready), 0);
      chk("R10 tx stays low", int'(tx), 0);
    end
    data_valid = 1'b0;
  endtask

  task automatic t_basic;
    launch(8'hA5, 8'hE8, 0, 0);
    stream(8'hA5, 8'hE8, 0, 0, 1'b0, 8'h00, 1'b0, "R3");
    @(negedge clk); #1;
    chk("R1 idle after message", int'(tx), 0);
  endtask

  task automatic t_prescale_pin;
    launch(8'h3C, 8'h96, 2, 1);
    stream(8'h3C, 8'h96, 2, 1, 1'b0, 8'h00, 1'b0, "R4 R5");
  endtask

  task automatic t_chain;
    launch(8'h81, 8'hC4, 1, 0);
    stream(8'h81, 8'hC4, 1, 0, 1'b1, 8'h7E, 1'b0, "R7 first");
    stream(8'h7E, 8'hC4, 1, 0, 1'b0, 8'h00, 1'b0, "R7 second");
  endtask

  task automatic t_cfg_hold;
    launch(8'h5A, 8'hB2, 1, 0);
    stream(8'h5A, 8'hB2, 1, 0, 1'b0, 8'h00, 1'b1, "R9");
  endtask

  task automatic t_abort;
    launch(8'hFF, 8'hF0, 3, 0);
    for (int n = 0; n < 14; n++) begin
      @(negedge clk);
      if (n == 0) data_valid = 1'b0;
      #1;
      chk("R8 tx", int'(tx), (n < 8) ? 1 : 0);
      chk("R8 no done", int'(done), 0);
      if (n == 5) start = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_ignore();
    t_basic();
    t_prescale_pin();
    t_chain();
    t_cfg_hold();
    t_abort();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule